// File: doc/BRIEF.md
# Transmit Frame Buffer with Collision Replay

This block is a byte-wide transmit buffer placed between a DMA engine that fills it and a MAC transmitter that drains it. The DMA side writes bytes and marks the final byte of each frame. The MAC side pops bytes while the block reports that it is transmitting. A request output tells the DMA engine that a full burst fits in the remaining space. The buffer never accepts more bytes than it can hold.

Transmission of a frame begins once a programmable number of its bytes has been buffered, or as soon as the whole frame is present. The first 64 bytes of each frame stay in storage while they are sent. If the MAC reports a collision inside that window, the read side rewinds and the frame is replayed from its first byte. A collision after the window raises a one-cycle late-collision pulse, and the rest of that frame is dropped. The start threshold and the burst length are sampled only while no frame is in progress.

Top module: `tx_retry_fifo`

## Requirements
- R1: After reset the block is idle (tx_busy=0, rd_valid=0, late_col=0), cfg_error=0, and dma_req=1, because the reset configuration (threshold 64, burst length 16) is valid and all 1024 entries are free.
- R2: The buffer holds 1024 entries. A write (wr_en=1) made while no entry is free is discarded, and a discarded write never reaches the read side.
- R3: dma_req is 1 exactly when the sampled configuration is valid and the free space (1024 minus occupied entries, retained bytes included) is at least the sampled burst length.
- R4: From idle, tx_busy rises one cycle after either of two conditions holds: the bytes buffered reach max(threshold, 1), or a complete frame (final byte written with wr_last=1) is stored.
- R5: While transmitting, rd_valid is 1 whenever an unread byte is stored. rd_data gives the bytes in write order, and rd_en=1 with rd_valid=1 consumes one. rd_last is 1 on the final byte of a frame, after which rd_valid stays 0 until the next frame starts.
- R6: Bytes of the frame in progress stay counted as occupied until 64 of them have been read, or until the frame is retired.
- R7: A collision (col_in=1) during a frame, before 64 bytes have been read, rewinds the read side to the frame's first byte. A pop in the same cycle is ignored. The bytes are then delivered again in the same order.
- R8: A collision after 64 bytes have been read gives late_col=1 for exactly one cycle. The unread bytes of that frame, up to and including its final byte, are dropped without being shown on rd_valid, and the block then returns to idle.
- R9: The configuration is an error when threshold > 256, or threshold + burst length > 1024, or 2 × burst length ≥ 1024. cfg_error is then 1 and dma_req is held at 0.
- R10: The threshold and burst-length inputs are sampled only while idle. Changing them during a frame has no effect on cfg_error, dma_req or the start decision until the block is idle again.
- R11: After the final byte is read, tx_done_in=1 retires the frame: the block goes idle and all of its bytes become free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_thresh | input | 9 | Bytes to buffer before a frame starts |
| cfg_burst_len | input | 11 | DMA burst length in bytes |
| cfg_error | output | 1 | Sampled configuration is invalid |
| dma_req | output | 1 | A full burst fits in free space |
| wr_en | input | 1 | Write one byte |
| wr_data | input | 8 | Byte to write |
| wr_last | input | 1 | Written byte ends its frame |
| tx_busy | output | 1 | A frame is being transmitted |
| rd_en | input | 1 | MAC consumes the byte shown |
| rd_valid | output | 1 | rd_data holds an unread byte |
| rd_data | output | 8 | Byte for the MAC |
| rd_last | output | 1 | Shown byte ends its frame |
| col_in | input | 1 | Collision reported by the MAC |
| tx_done_in | input | 1 | MAC finished the frame |
| late_col | output | 1 | One-cycle pulse for a late collision |

## Verification
Three situations are hardest to reach. The first is a full buffer whose space is partly held by retained frame bytes. The bench stops the reader after the frame has started and keeps writing past 1024 bytes without watching dma_req, then lets reading resume and sends the final byte only after the 64-byte window has released space. The second and third are collisions aimed at an exact byte count. The bench pulses col_in when its own model reports 30 or 80 bytes read. It also aims one collision at a short frame that is waiting for tx_done_in, which shows that retention reaches past the last byte.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
    localparam int DW = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_DROP
    } tfr_state_e;

    typedef struct packed {
        logic          last;
        logic [DW-1:0] data;
    } tfr_entry_t;

    // Invalid when the threshold is too big, threshold plus burst does not fit,
    // or the burst takes half the buffer or more.
    function automatic logic cfg_bad(int th, int pbl, int depth, int th_max);
        return (th > th_max) || (th + pbl > depth) || (2 * pbl >= depth);
    endfunction
endpackage

// File: rtl/tfr_store.sv
module tfr_store
    import tfr_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10,
    parameter int PW    = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_go,
    input  tfr_entry_t wr_entry,
    input  logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] wr_ptr,
    output tfr_entry_t rd_entry
);
    tfr_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_ptr[AW-1:0]] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst)        wr_ptr <= '0;
        else if (wr_go) wr_ptr <= wr_ptr + PW'(1);
    end

    assign rd_entry = mem[rd_ptr[AW-1:0]];
endmodule

// File: rtl/tfr_space.sv
module tfr_space
    import tfr_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int PW      = 11,
    parameter int THW     = 9,
    parameter int TH_MAX  = 256,
    parameter int TH_RST  = 64,
    parameter int PBL_RST = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           idle,
    input  logic [THW-1:0] cfg_th,
    input  logic [PW-1:0]  cfg_pbl,
    input  logic [PW-1:0]  wr_ptr,
    input  logic [PW-1:0]  base_ptr,
    input  logic           wr_en,
    output logic [THW-1:0] th_q,
    output logic           cfg_error,
    output logic           dma_req,
    output logic           wr_go
);
    logic [PW-1:0] pbl_q;
    logic [PW-1:0] used;
    logic [PW-1:0] free;

    always_ff @(posedge clk) begin
        if (rst) begin
            th_q  <= THW'(TH_RST);
            pbl_q <= PW'(PBL_RST);
        end else if (idle) begin
            th_q  <= cfg_th;
            pbl_q <= cfg_pbl;
        end
    end

    assign used      = wr_ptr - base_ptr;
    assign free      = PW'(DEPTH) - used;
    assign cfg_error = cfg_bad(int'(th_q), int'(pbl_q), DEPTH, TH_MAX);
    assign dma_req   = !cfg_error && (free >= pbl_q);
    assign wr_go     = wr_en && (free != '0);
endmodule

// File: rtl/tfr_ctrl.sv
module tfr_ctrl
    import tfr_pkg::*;
#(
    parameter int PW  = 11,
    parameter int THW = 9,
    parameter int WIN = 64,
    parameter int SW  = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [THW-1:0] th_q,
    input  logic [PW-1:0]  wr_ptr,
    input  logic           frame_in,
    input  logic           head_last,
    input  logic           rd_en,
    input  logic           col_in,
    input  logic           tx_done_in,
    output logic [PW-1:0]  rd_ptr,
    output logic [PW-1:0]  base_ptr,
    output logic [SW-1:0]  sent_cnt,
    output tfr_state_e     st,
    output logic           late_col,
    output logic           rd_valid,
    output logic           tx_busy
);
    logic [PW-1:0]  frames;
    logic [PW-1:0]  level;
    logic [THW-1:0] need;
    logic           have;
    logic           win_done;
    logic [SW-1:0]  sent_nx;
    logic           frame_out;

    assign level    = wr_ptr - rd_ptr;
    assign need     = (th_q == '0) ? THW'(1) : th_q;
    assign have     = (wr_ptr != rd_ptr);
    assign win_done = (sent_cnt == SW'(WIN));
    assign sent_nx  = win_done ? sent_cnt : sent_cnt + SW'(1);
    assign rd_valid = (st == ST_SEND) && have;
    assign tx_busy  = (st == ST_SEND) || (st == ST_WAIT);

    always_comb begin
        frame_out = 1'b0;
        unique case (st)
            ST_WAIT: frame_out = col_in ? win_done : tx_done_in;
            ST_DROP: frame_out = have && head_last;
            default: frame_out = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            rd_ptr   <= '0;
            base_ptr <= '0;
            sent_cnt <= '0;
            frames   <= '0;
            late_col <= 1'b0;
        end else begin
            late_col <= 1'b0;
            frames   <= frames + PW'(frame_in) - PW'(frame_out);
            unique case (st)
                ST_IDLE: begin
                    if (frames != '0 || level >= PW'(need)) begin
                        st       <= ST_SEND;
                        sent_cnt <= '0;
                    end
                end
                ST_SEND: begin
                    if (col_in) begin
                        if (!win_done) begin
                            rd_ptr   <= base_ptr;
                            sent_cnt <= '0;
                        end else begin
                            late_col <= 1'b1;
                            st       <= ST_DROP;
                        end
                    end else if (rd_en && have) begin
                        rd_ptr   <= rd_ptr + PW'(1);
                        sent_cnt <= sent_nx;
                        if (sent_nx == SW'(WIN)) base_ptr <= rd_ptr + PW'(1);
                        if (head_last) st <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (col_in) begin
                        if (!win_done) begin
                            rd_ptr   <= base_ptr;
                            sent_cnt <= '0;
                            st       <= ST_SEND;
                        end else begin
                            late_col <= 1'b1;
                            st       <= ST_IDLE;
                        end
                    end else if (tx_done_in) begin
                        base_ptr <= rd_ptr;
                        st       <= ST_IDLE;
                    end
                end
                ST_DROP: begin
                    if (have) begin
                        rd_ptr   <= rd_ptr + PW'(1);
                        base_ptr <= rd_ptr + PW'(1);
                        if (head_last) st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tx_retry_fifo.sv
module tx_retry_fifo
    import tfr_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int WIN     = 64,
    parameter int TH_MAX  = 256,
    parameter int TH_RST  = 64,
    parameter int PBL_RST = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1,
    localparam int THW    = $clog2(TH_MAX + 1),
    localparam int SW     = $clog2(WIN + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [THW-1:0] cfg_start_thresh,
    input  logic [PW-1:0]  cfg_burst_len,
    output logic           cfg_error,
    output logic           dma_req,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    input  logic           wr_last,
    output logic           tx_busy,
    input  logic           rd_en,
    output logic           rd_valid,
    output logic [DW-1:0]  rd_data,
    output logic           rd_last,
    input  logic           col_in,
    input  logic           tx_done_in,
    output logic           late_col
);
    logic [PW-1:0]  wr_ptr;
    logic [PW-1:0]  rd_ptr;
    logic [PW-1:0]  base_ptr;
    logic [SW-1:0]  sent_cnt;
    logic [THW-1:0] th_q;
    logic           wr_go;
    tfr_state_e     st;
    tfr_entry_t     wr_entry;
    tfr_entry_t     rd_entry;

    assign wr_entry = '{last: wr_last, data: wr_data};

    tfr_store #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_store (
        .clk(clk), .rst(rst), .wr_go(wr_go), .wr_entry(wr_entry),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .rd_entry(rd_entry)
    );

    tfr_space #(.DEPTH(DEPTH), .PW(PW), .THW(THW), .TH_MAX(TH_MAX),
                .TH_RST(TH_RST), .PBL_RST(PBL_RST)) u_space (
        .clk(clk), .rst(rst), .idle(st == ST_IDLE),
        .cfg_th(cfg_start_thresh), .cfg_pbl(cfg_burst_len),
        .wr_ptr(wr_ptr), .base_ptr(base_ptr), .wr_en(wr_en),
        .th_q(th_q), .cfg_error(cfg_error), .dma_req(dma_req), .wr_go(wr_go)
    );

    tfr_ctrl #(.PW(PW), .THW(THW), .WIN(WIN), .SW(SW)) u_ctrl (
        .clk(clk), .rst(rst), .th_q(th_q), .wr_ptr(wr_ptr),
        .frame_in(wr_go && wr_last), .head_last(rd_entry.last),
        .rd_en(rd_en), .col_in(col_in), .tx_done_in(tx_done_in),
        .rd_ptr(rd_ptr), .base_ptr(base_ptr), .sent_cnt(sent_cnt), .st(st),
        .late_col(late_col), .rd_valid(rd_valid), .tx_busy(tx_busy)
    );

    assign rd_data = rd_entry.data;
    assign rd_last = rd_valid && rd_entry.last;
endmodule

module tfr_checker #(
    parameter int DEPTH = 1024,
    parameter int WIN   = 64,
    parameter int PW    = 11,
    parameter int SW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr,
    input logic [PW-1:0] base_ptr,
    input logic [SW-1:0] sent_cnt,
    input logic          tx_busy,
    input logic          rd_valid,
    input logic          dma_req,
    input logic          cfg_error,
    input logic          col_in,
    input logic          late_col
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!tx_busy && !rd_valid && !late_col));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr - base_ptr) <= PW'(DEPTH));

    assert_retain_window_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr - base_ptr) < PW'(WIN));

    assert_read_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> tx_busy);

    assert_rewind_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && col_in && sent_cnt < SW'(WIN)) |=> (rd_ptr == $past(base_ptr) && tx_busy));

    assert_late_window_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(late_col) |-> ($past(sent_cnt) == SW'(WIN)));

    assert_late_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        late_col |=> !late_col);

    assert_error_gate_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_error |-> !dma_req);
endmodule

bind tx_retry_fifo tfr_checker #(.DEPTH(DEPTH), .WIN(WIN), .PW(PW), .SW(SW)) u_chk (
    .clk(clk), .rst(rst), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .base_ptr(base_ptr),
    .sent_cnt(sent_cnt), .tx_busy(tx_busy), .rd_valid(rd_valid), .dma_req(dma_req),
    .cfg_error(cfg_error), .col_in(col_in), .late_col(late_col)
);

// File: tb/sim_tx_retry_fifo.sv
`timescale 1ns/1ps
module sim_tx_retry_fifo;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  cfg_start_thresh = 9'd64;
    logic [10:0] cfg_burst_len = 11'd16;
    logic        cfg_error, dma_req, tx_busy, rd_valid, rd_last, late_col;
    logic        wr_en = 1'b0, wr_last = 1'b0, rd_en = 1'b0, col_in = 1'b0, tx_done_in = 1'b0;
    logic [7:0]  wr_data = 8'd0, rd_data;

    always #5 clk = ~clk;

    tx_retry_fifo u0 (
        .clk(clk), .rst(rst), .cfg_start_thresh(cfg_start_thresh),
        .cfg_burst_len(cfg_burst_len), .cfg_error(cfg_error), .dma_req(dma_req),
        .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .tx_busy(tx_busy),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .col_in(col_in), .tx_done_in(tx_done_in), .late_col(late_col)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit mac_on = 0;

    // behavioural reference model
    bit [8:0] q[$];
    int ro = 0, m_st = 0, m_sent = 0, m_frames = 0, m_th = 64, m_pbl = 16;
    bit m_late = 0;

    function automatic bit m_err();
        return (m_th > 256) || (m_th + m_pbl > 1024) || (2 * m_pbl >= 1024);
    endfunction
    function automatic bit m_dma();
        return !m_err() && ((1024 - q.size()) >= m_pbl);
    endfunction
    function automatic bit m_rv();
        return (m_st == 1) && (ro < q.size());
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            q.delete(); ro = 0; m_st = 0; m_sent = 0; m_frames = 0;
            m_th = 64; m_pbl = 16; m_late = 0;
        end else begin
            int  free0;
            bit  wacc;
            int  dec;
            bit  nl;
            bit [8:0] e;
            free0 = 1024 - q.size();
            wacc  = wr_en && (free0 > 0);
            dec   = 0;
            nl    = 0;
            case (m_st)
                0: begin
                    if (m_frames > 0 || q.size() >= ((m_th == 0) ? 1 : m_th)) begin
                        m_st = 1; m_sent = 0;
                    end
                    m_th  = int'(cfg_start_thresh);
                    m_pbl = int'(cfg_burst_len);
                end
                1: begin
                    if (col_in) begin
                        if (m_sent < 64) begin ro = 0; m_sent = 0; end
                        else begin nl = 1; m_st = 3; end
                    end else if (rd_en && ro < q.size()) begin
                        e = q[ro]; ro++; m_sent++;
                        if (m_sent >= 64) begin repeat (ro) void'(q.pop_front()); ro = 0; end
                        if (e[8]) m_st = 2;
                    end
                end
                2: begin
                    if (col_in) begin
                        if (m_sent < 64) begin ro = 0; m_sent = 0; m_st = 1; end
                        else begin nl = 1; m_st = 0; dec = 1; end
                    end else if (tx_done_in) begin
                        repeat (ro) void'(q.pop_front()); ro = 0; m_st = 0; dec = 1;
                    end
                end
                default: begin
                    if (q.size() > 0) begin
                        e = q.pop_front();
                        if (e[8]) begin m_st = 0; dec = 1; end
                    end
                end
            endcase
            if (wacc) q.push_back({wr_last, wr_data});
            m_frames = m_frames + int'(wacc && wr_last) - dec;
            m_late = nl;
        end
        if (cyc == 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected=0", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(dma_req == m_dma(), "R3 R2 R6 R9 dma_req", dma_req, m_dma());
            chk(cfg_error == m_err(), "R9 R10 cfg_error", cfg_error, m_err());
            chk(tx_busy == (m_st == 1 || m_st == 2), "R4 R10 R11 tx_busy", tx_busy, (m_st == 1 || m_st == 2));
            chk(rd_valid == m_rv(), "R5 R8 rd_valid", rd_valid, m_rv());
            chk(late_col == m_late, "R8 late_col", late_col, m_late);
            if (rd_valid && m_rv()) begin
                chk(rd_data == q[ro][7:0], "R5 R7 rd_data", rd_data, q[ro][7:0]);
                chk(rd_last == q[ro][8], "R5 rd_last", rd_last, q[ro][8]);
            end
        end
    end

    // MAC side: drains while enabled, reports done one cycle after the last byte
    always @(negedge clk) begin
        rd_en = mac_on;
        tx_done_in = mac_on && (m_st == 2) && !tx_done_in;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_frame(int len, int seed, bit gated, bit with_last);
        for (int i = 0; i < len; i++) begin
            while (gated && !dma_req) @(negedge clk);
            wr_en = 1'b1; wr_data = 8'(seed + i); wr_last = with_last && (i == len - 1);
            @(negedge clk);
        end
        wr_en = 1'b0; wr_last = 1'b0;
    endtask

    task automatic wait_idle();
        while (!(m_st == 0 && m_frames == 0)) @(negedge clk);
        tick(2);
    endtask

    task automatic col_at(int n, int state);
        while (!(m_st == state && (state == 2 || m_sent == n))) @(negedge clk);
        col_in = 1'b1;
        @(negedge clk);
        col_in = 1'b0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(dma_req == 1'b1, "R1 dma_req after reset", dma_req, 1);
        chk(tx_busy == 1'b0 && rd_valid == 1'b0, "R1 idle after reset", tx_busy, 0);
        chk(late_col == 1'b0 && cfg_error == 1'b0, "R1 flags after reset", cfg_error, 0);

        // normal frame, gated DMA, continuous MAC (R3 R4 R5 R11)
        mac_on = 1;
        put_frame(100, 8'h10, 1, 1);
        wait_idle();

        // short frame below threshold starts only once complete (R4)
        put_frame(19, 8'h40, 0, 0);
        tick(5);
        chk(tx_busy == 1'b0, "R4 short frame held below threshold", tx_busy, 0);
        put_frame(1, 8'h53, 0, 1);
        tick(2);
        chk(tx_busy == 1'b1, "R4 complete frame starts", tx_busy, 1);
        wait_idle();

        // threshold zero starts on the first byte (R4)
        cfg_start_thresh = 9'd0;
        tick(2);
        put_frame(40, 8'h60, 0, 1);
        wait_idle();
        cfg_start_thresh = 9'd64;
        tick(2);

        // early collision at 30 bytes, replay (R7)
        fork
            put_frame(120, 8'h80, 0, 1);
            col_at(30, 1);
        join
        wait_idle();

        // collision on a short frame waiting for done (R6 R7)
        fork
            put_frame(30, 8'hA0, 0, 1);
            col_at(0, 2);
        join
        wait_idle();

        // late collision at 80 bytes, rest dropped, next frame intact (R8)
        fork
            put_frame(200, 8'hC0, 0, 1);
            col_at(80, 1);
        join
        wait_idle();
        chk(tx_busy == 1'b0, "R8 idle after late collision drop", tx_busy, 0);
        put_frame(50, 8'h05, 0, 1);
        wait_idle();

        // fill past capacity with reader stopped (R2 R6)
        mac_on = 0;
        cfg_start_thresh = 9'd256;
        tick(2);
        put_frame(1030, 8'h11, 0, 0);
        chk(dma_req == 1'b0, "R2 full buffer holds request", dma_req, 0);
        mac_on = 1;
        tick(100);
        put_frame(1, 8'hEE, 0, 1);
        wait_idle();
        cfg_start_thresh = 9'd64;
        tick(2);

        // configuration errors (R9)
        cfg_burst_len = 11'd600; tick(3);
        chk(cfg_error == 1'b1 && dma_req == 1'b0, "R9 burst 600", cfg_error, 1);
        cfg_burst_len = 11'd512; tick(3);
        chk(cfg_error == 1'b1, "R9 burst 512", cfg_error, 1);
        cfg_burst_len = 11'd511; tick(3);
        chk(cfg_error == 1'b0, "R9 burst 511", cfg_error, 0);
        cfg_burst_len = 11'd16; cfg_start_thresh = 9'd300; tick(3);
        chk(cfg_error == 1'b1, "R9 threshold 300", cfg_error, 1);
        cfg_start_thresh = 9'd256; cfg_burst_len = 11'd256; tick(3);
        chk(cfg_error == 1'b0, "R9 threshold 256 burst 256", cfg_error, 0);
        cfg_start_thresh = 9'd64; cfg_burst_len = 11'd128; tick(3);

        // configuration change mid-frame ignored (R10)
        fork
            put_frame(300, 8'h33, 1, 1);
            begin
                while (!tx_busy) @(negedge clk);
                cfg_burst_len = 11'd700;
                tick(4);
                chk(cfg_error == 1'b0, "R10 burst change ignored while busy", cfg_error, 0);
            end
        join
        wait_idle();
        chk(cfg_error == 1'b1, "R10 burst sampled once idle", cfg_error, 1);
        cfg_burst_len = 11'd16;
        tick(3);
        put_frame(64, 8'h99, 1, 1);
        wait_idle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule